// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet Buffer

This block is the packet store for a single bulk or isochronous endpoint of a full-speed USB device. It holds two packets per direction. The serial protocol engine can fill or empty one packet while the processor or a DMA engine works on the other. Bit coding, CRC generation and checking, PID handling and the system bus lie outside it. The protocol engine passes in decoded bytes together with a verdict on each packet. The consumer side sees a byte-wide read port.

For host-to-device traffic, bytes land in a free buffer while the packet is still being checked. The packet becomes readable only when the engine reports a good CRC and the length does not exceed the maximum. Otherwise the bytes are dropped and a NAK request is pulsed. The block raises a DMA request for full-size packets, in chunks of a parameterized size. It raises separate one-cycle interrupts for full-size, short and zero-length packets.

For device-to-host traffic, the processor writes a packet and commits it. The packet stays stored until the engine reports an ACK, so a retry replays the same bytes without a reload. An ACK releases the buffer and brings the other packet forward.

Top module: `dbl_ep_buffer`

## Requirements
- R1: After reset both directions are empty: `out_avail`=0, `in_avail`=0, `rx_busy`=0, `tx_ready`=1, and `dma_req`, `rx_nak`, `irq_pkt`, `irq_short`, `irq_zlp` are all 0.
- R2: A received packet closed by `rx_eop` with `rx_crc_ok`=1 and at most MAX_PKT bytes is readable from the cycle after `rx_eop`. `out_len` gives its length, `out_data` presents its bytes in arrival order as `out_rd` advances, and `out_last`=1 on the final byte. The `rx_eop` cycle carries no data byte.
- R3: A packet closed with `rx_crc_ok`=0, or one that carried more than MAX_PKT bytes, is discarded and leaves `out_avail` unchanged. It raises `rx_nak` for exactly the one cycle after `rx_eop`, and no interrupt.
- R4: Two good packets can be held at once, and they are read in arrival order. While both are held, `rx_busy`=1 and a new `rx_sop` with its bytes and `rx_eop` is ignored entirely: no data is stored, no interrupt and no NAK.
- R5: `out_rd` on the last byte of a packet (or on a zero-length packet) frees that buffer. The next held packet is then presented, or `out_avail` falls if no packet is held.
- R6: A committed packet pulses exactly one interrupt for one cycle, the cycle after `rx_eop`: `irq_pkt` for MAX_PKT bytes, `irq_short` for 1 to MAX_PKT-1 bytes, `irq_zlp` for 0 bytes (which shows `out_len`=0 and `out_last`=1).
- R7: `dma_req` is 1 only while a full-size packet is readable and at least CHUNK of its bytes remain unread. It is 0 for short and zero-length packets.
- R8: For the IN direction, `tx_wr` stores `tx_wdata` in the free buffer and `tx_commit` closes the packet. The cycle after commit, `in_avail`=1, `in_len` shows the length, and `in_rd` steps through the bytes with `in_last`=1 on the final one.
- R9: `in_retry` on a held IN packet rewinds reading to its first byte. The stored data is replayed unchanged.
- R10: `in_ack` on a held IN packet frees it. The next committed packet becomes current, and `tx_ready` is 1 in the following cycle.
- R11: While two IN packets are held, `tx_ready`=0 and both `tx_wr` and `tx_commit` are ignored.
- R12: IN bytes written beyond MAX_PKT in one packet are ignored, so its length saturates at MAX_PKT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sop | input | 1 | Start of a received data packet |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | End of the received packet (no byte this cycle) |
| rx_crc_ok | input | 1 | Validity verdict, sampled with `rx_eop` |
| rx_busy | output | 1 | No free receive buffer; engine should NAK |
| rx_nak | output | 1 | Pulse: packet discarded, NAK requested |
| out_rd | input | 1 | Consume the presented byte |
| out_avail | output | 1 | A verified packet is readable |
| out_data | output | 8 | Presented byte |
| out_last | output | 1 | Presented byte is the packet's last |
| out_len | output | clog2(MAX_PKT+1) | Length of the readable packet |
| dma_req | output | 1 | DMA chunk request for a full-size packet |
| irq_pkt | output | 1 | Pulse: full-size packet committed |
| irq_short | output | 1 | Pulse: short packet committed |
| irq_zlp | output | 1 | Pulse: zero-length packet committed |
| tx_wr | input | 1 | Write a byte into the IN fill buffer |
| tx_wdata | input | 8 | IN byte |
| tx_commit | input | 1 | Close the IN packet being filled |
| tx_ready | output | 1 | An IN fill buffer is free |
| in_rd | input | 1 | Advance to the next IN byte |
| in_retry | input | 1 | Rewind the current IN packet |
| in_ack | input | 1 | Host acknowledged; free the current IN packet |
| in_avail | output | 1 | An IN packet is held |
| in_data | output | 8 | Current IN byte |
| in_last | output | 1 | Current IN byte is the packet's last |
| in_len | output | clog2(MAX_PKT+1) | Length of the current IN packet |

## Verification
The checker watches several properties on every cycle. A NAK never coincides with an interrupt and lasts one cycle. At most one packet-class interrupt fires, and only with data readable. A DMA request implies a full-size readable packet. Receive back-pressure and blocked IN writes occur only with packets held. An ACK always frees a fill buffer, and a retry keeps the current length. Other behaviours can only be shown by the bench's scenarios: byte order across two buffered packets, the exact drop of a busy-time packet, replay of the same IN bytes after a retry, the DMA chunk boundary inside a packet, and length saturation.

// File: rtl/ep_fifo_pkg.sv
package ep_fifo_pkg;
    typedef logic [7:0] byte_t;

    localparam int unsigned DEF_MAX_PKT = 64;
    localparam int unsigned DEF_CHUNK   = 32;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_FULL  = 2'd1,
        CLS_SHORT = 2'd2,
        CLS_ZERO  = 2'd3
    } pkt_class_e;

    function automatic pkt_class_e classify(input int unsigned len, input int unsigned maxlen);
        if (len == 0) return CLS_ZERO;
        if (len >= maxlen) return CLS_FULL;
        return CLS_SHORT;
    endfunction
endpackage

// File: rtl/pp_mem.sv
module pp_mem
    import ep_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbuf,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic          rbuf,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata
);
    byte_t rd_b [2];

    for (genvar b = 0; b < 2; b++) begin : g_buf
        byte_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && (wbuf == 1'(b))) mem[waddr] <= wdata;
        end
        assign rd_b[b] = mem[raddr];
    end

    assign rdata = rd_b[rbuf];
endmodule

// File: rtl/ep_out_path.sv
module ep_out_path
    import ep_fifo_pkg::*;
#(
    parameter int unsigned MAX_PKT = DEF_MAX_PKT,
    parameter int unsigned CHUNK   = DEF_CHUNK,
    localparam int unsigned CW = $clog2(MAX_PKT + 1),
    localparam int unsigned AW = $clog2(MAX_PKT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_sop,
    input  logic          rx_valid,
    input  byte_t         rx_data,
    input  logic          rx_eop,
    input  logic          rx_crc_ok,
    output logic          rx_busy,
    output logic          rx_nak,
    input  logic          out_rd,
    output logic          out_avail,
    output byte_t         out_data,
    output logic          out_last,
    output logic [CW-1:0] out_len,
    output logic          dma_req,
    output logic          irq_pkt,
    output logic          irq_short,
    output logic          irq_zlp
);
    localparam logic [CW-1:0] MAX_C   = CW'(MAX_PKT);
    localparam logic [CW-1:0] CHUNK_C = CW'(CHUNK);

    typedef struct packed {
        logic                wsel;
        logic                rsel;
        logic [1:0]          full;
        logic [1:0][CW-1:0]  cnt;
        logic [CW-1:0]       wptr;
        logic [CW-1:0]       rptr;
        logic                act;
        logic                bad;
        logic                nak;
        pkt_class_e          cls;
    } out_st_t;

    out_st_t st_d, st_q;
    logic    we_d;
    logic [CW-1:0] cur_cnt;
    logic          cur_last;

    assign cur_cnt  = st_q.cnt[st_q.rsel];
    assign cur_last = (st_q.rptr + CW'(1)) >= cur_cnt;

    always_comb begin
        st_d     = st_q;
        st_d.nak = 1'b0;
        st_d.cls = CLS_NONE;
        we_d     = 1'b0;
        // receive side: sop opens a packet only when the write buffer is free
        if (rx_sop && !st_q.full[st_q.wsel]) begin
            st_d.act  = 1'b1;
            st_d.wptr = '0;
            st_d.bad  = 1'b0;
        end else if (st_q.act) begin
            if (rx_valid) begin
                if (st_q.wptr < MAX_C) begin
                    we_d      = 1'b1;
                    st_d.wptr = st_q.wptr + CW'(1);
                end else begin
                    st_d.bad = 1'b1;
                end
            end
            if (rx_eop) begin
                st_d.act = 1'b0;
                if (rx_crc_ok && !st_q.bad) begin
                    st_d.full[st_q.wsel] = 1'b1;
                    st_d.cnt[st_q.wsel]  = st_q.wptr;
                    st_d.wsel            = ~st_q.wsel;
                    st_d.cls             = classify(32'(st_q.wptr), MAX_PKT);
                end else begin
                    st_d.nak = 1'b1;
                end
            end
        end
        // consumer side
        if (out_rd && st_q.full[st_q.rsel]) begin
            if (cur_last) begin
                st_d.full[st_q.rsel] = 1'b0;
                st_d.rsel            = ~st_q.rsel;
                st_d.rptr            = '0;
            end else begin
                st_d.rptr = st_q.rptr + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pp_mem #(.DEPTH(MAX_PKT)) u_mem (
        .clk   (clk),
        .we    (we_d),
        .wbuf  (st_q.wsel),
        .waddr (st_q.wptr[AW-1:0]),
        .wdata (rx_data),
        .rbuf  (st_q.rsel),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (out_data)
    );

    assign rx_busy   = st_q.full[st_q.wsel];
    assign rx_nak    = st_q.nak;
    assign out_avail = st_q.full[st_q.rsel];
    assign out_last  = out_avail && cur_last;
    assign out_len   = cur_cnt;
    assign dma_req   = out_avail && (cur_cnt == MAX_C) && ((cur_cnt - st_q.rptr) >= CHUNK_C);
    assign irq_pkt   = st_q.cls == CLS_FULL;
    assign irq_short = st_q.cls == CLS_SHORT;
    assign irq_zlp   = st_q.cls == CLS_ZERO;
endmodule

// File: rtl/ep_in_path.sv
module ep_in_path
    import ep_fifo_pkg::*;
#(
    parameter int unsigned MAX_PKT = DEF_MAX_PKT,
    localparam int unsigned CW = $clog2(MAX_PKT + 1),
    localparam int unsigned AW = $clog2(MAX_PKT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_wr,
    input  byte_t         tx_wdata,
    input  logic          tx_commit,
    output logic          tx_ready,
    input  logic          in_rd,
    input  logic          in_retry,
    input  logic          in_ack,
    output logic          in_avail,
    output byte_t         in_data,
    output logic          in_last,
    output logic [CW-1:0] in_len
);
    localparam logic [CW-1:0] MAX_C = CW'(MAX_PKT);

    typedef struct packed {
        logic                wsel;
        logic                rsel;
        logic [1:0]          full;
        logic [1:0][CW-1:0]  cnt;
        logic [CW-1:0]       wptr;
        logic [CW-1:0]       rptr;
    } in_st_t;

    in_st_t st_d, st_q;
    logic   we_d;
    logic [CW-1:0] cur_cnt;

    assign cur_cnt = st_q.cnt[st_q.rsel];

    always_comb begin
        st_d = st_q;
        we_d = 1'b0;
        // fill side: only while the fill buffer is free
        if (!st_q.full[st_q.wsel]) begin
            if (tx_commit) begin
                st_d.full[st_q.wsel] = 1'b1;
                st_d.cnt[st_q.wsel]  = st_q.wptr;
                st_d.wptr            = '0;
                st_d.wsel            = ~st_q.wsel;
            end else if (tx_wr && (st_q.wptr < MAX_C)) begin
                we_d      = 1'b1;
                st_d.wptr = st_q.wptr + CW'(1);
            end
        end
        // serial side: ack frees, retry rewinds, read advances
        if (st_q.full[st_q.rsel]) begin
            if (in_ack) begin
                st_d.full[st_q.rsel] = 1'b0;
                st_d.rsel            = ~st_q.rsel;
                st_d.rptr            = '0;
            end else if (in_retry) begin
                st_d.rptr = '0;
            end else if (in_rd && (st_q.rptr < cur_cnt)) begin
                st_d.rptr = st_q.rptr + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pp_mem #(.DEPTH(MAX_PKT)) u_mem (
        .clk   (clk),
        .we    (we_d),
        .wbuf  (st_q.wsel),
        .waddr (st_q.wptr[AW-1:0]),
        .wdata (tx_wdata),
        .rbuf  (st_q.rsel),
        .raddr (st_q.rptr[AW-1:0]),
        .rdata (in_data)
    );

    assign tx_ready = !st_q.full[st_q.wsel];
    assign in_avail = st_q.full[st_q.rsel];
    assign in_last  = in_avail && ((st_q.rptr + CW'(1)) >= cur_cnt);
    assign in_len   = cur_cnt;
endmodule

// File: rtl/dbl_ep_buffer.sv
module dbl_ep_buffer
    import ep_fifo_pkg::*;
#(
    parameter int unsigned MAX_PKT = DEF_MAX_PKT,
    parameter int unsigned CHUNK   = DEF_CHUNK
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_sop,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic                         rx_eop,
    input  logic                         rx_crc_ok,
    output logic                         rx_busy,
    output logic                         rx_nak,
    input  logic                         out_rd,
    output logic                         out_avail,
    output logic [7:0]                   out_data,
    output logic                         out_last,
    output logic [$clog2(MAX_PKT+1)-1:0] out_len,
    output logic                         dma_req,
    output logic                         irq_pkt,
    output logic                         irq_short,
    output logic                         irq_zlp,
    input  logic                         tx_wr,
    input  logic [7:0]                   tx_wdata,
    input  logic                         tx_commit,
    output logic                         tx_ready,
    input  logic                         in_rd,
    input  logic                         in_retry,
    input  logic                         in_ack,
    output logic                         in_avail,
    output logic [7:0]                   in_data,
    output logic                         in_last,
    output logic [$clog2(MAX_PKT+1)-1:0] in_len
);
    ep_out_path #(.MAX_PKT(MAX_PKT), .CHUNK(CHUNK)) u_out (
        .clk(clk), .rst_n(rst_n),
        .rx_sop(rx_sop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
        .rx_busy(rx_busy), .rx_nak(rx_nak),
        .out_rd(out_rd), .out_avail(out_avail), .out_data(out_data),
        .out_last(out_last), .out_len(out_len), .dma_req(dma_req),
        .irq_pkt(irq_pkt), .irq_short(irq_short), .irq_zlp(irq_zlp)
    );

    ep_in_path #(.MAX_PKT(MAX_PKT)) u_in (
        .clk(clk), .rst_n(rst_n),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_commit(tx_commit),
        .tx_ready(tx_ready),
        .in_rd(in_rd), .in_retry(in_retry), .in_ack(in_ack),
        .in_avail(in_avail), .in_data(in_data), .in_last(in_last),
        .in_len(in_len)
    );
endmodule

// File: rtl/ep_fifo_chk.sv
module ep_fifo_chk #(
    parameter int unsigned MAX_PKT = 64
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         rx_busy,
    input logic                         rx_nak,
    input logic                         out_avail,
    input logic [$clog2(MAX_PKT+1)-1:0] out_len,
    input logic                         dma_req,
    input logic                         irq_pkt,
    input logic                         irq_short,
    input logic                         irq_zlp,
    input logic                         tx_ready,
    input logic                         in_retry,
    input logic                         in_ack,
    input logic                         in_avail,
    input logic [$clog2(MAX_PKT+1)-1:0] in_len
);
    AST_NAK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nak |-> !(irq_pkt || irq_short || irq_zlp)); // R3
    AST_NAK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_nak |=> !rx_nak); // R3
    AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_pkt, irq_short, irq_zlp})); // R6
    AST_IRQ_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pkt || irq_short || irq_zlp) |-> out_avail); // R2
    AST_DMA_FULL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (out_avail && (out_len == ($clog2(MAX_PKT+1))'(MAX_PKT)))); // R7
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> out_avail); // R4
    AST_TX_BLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> in_avail); // R11
    AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack && in_avail) |=> tx_ready); // R10
    AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_retry && in_avail && !in_ack) |=> (in_avail && $stable(in_len))); // R9
endmodule

bind dbl_ep_buffer ep_fifo_chk #(.MAX_PKT(MAX_PKT)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_busy(rx_busy), .rx_nak(rx_nak),
    .out_avail(out_avail), .out_len(out_len), .dma_req(dma_req),
    .irq_pkt(irq_pkt), .irq_short(irq_short), .irq_zlp(irq_zlp),
    .tx_ready(tx_ready), .in_retry(in_retry), .in_ack(in_ack),
    .in_avail(in_avail), .in_len(in_len)
);

// File: tb/dbl_ep_buffer_test.sv
`timescale 1ns/1ps
module dbl_ep_buffer_test;
    localparam int MAXP = 64;
    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_sop = 0, rx_valid = 0, rx_eop = 0, rx_crc_ok = 0, out_rd = 0;
    logic [7:0] rx_data = 0, tx_wdata = 0;
    logic tx_wr = 0, tx_commit = 0, in_rd = 0, in_retry = 0, in_ack = 0;
    logic rx_busy, rx_nak, out_avail, out_last, dma_req, irq_pkt, irq_short, irq_zlp;
    logic tx_ready, in_avail, in_last;
    logic [7:0] out_data, in_data;
    logic [6:0] out_len, in_len;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [8:0] exp_q[$];   // {last, data}

    always #2 clk = ~clk;   // 250 MHz

    dbl_ep_buffer uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: compares every consumed OUT byte against the scoreboard
    initial forever begin
        @(negedge clk); #1;
        if (out_rd && out_avail && out_len != 0) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: actual %0h expected none (queue empty)", {out_last, out_data});
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({out_last, out_data} !== e) begin
                    n_fail++;
                    $display("FAIL R2: actual %0h expected %0h", {out_last, out_data}, e);
                end
            end
        end
    end

    // driver: sends one OUT packet, pushes the bytes expected to be committed
    task automatic send_out(int len, logic [7:0] seed, bit good, bit accept);
        @(negedge clk) rx_sop = 1;
        @(negedge clk) rx_sop = 0;
        for (int i = 0; i < len; i++) begin
            rx_valid = 1; rx_data = seed + 8'(i);
            if (good && accept && len <= MAXP) exp_q.push_back({(i == len - 1), rx_data});
            @(negedge clk);
        end
        rx_valid = 0; rx_eop = 1; rx_crc_ok = good;
        @(negedge clk);
        rx_eop = 0; rx_crc_ok = 0;
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) begin
            out_rd = 1;
            @(negedge clk);
        end
        out_rd = 0;
    endtask

    task automatic in_write(int len, logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            tx_wr = 1; tx_wdata = seed + 8'(i);
            @(negedge clk);
        end
        tx_wr = 0;
    endtask

    task automatic pulse_commit(); tx_commit = 1; @(negedge clk); tx_commit = 0; endtask
    task automatic pulse_retry();  in_retry  = 1; @(negedge clk); in_retry  = 0; endtask
    task automatic pulse_ack();    in_ack    = 1; @(negedge clk); in_ack    = 0; endtask
    task automatic in_step();      in_rd     = 1; @(negedge clk); in_rd     = 0; endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_avail", out_avail, 0);
        chk("R1 in_avail", in_avail, 0);
        chk("R1 rx_busy", rx_busy, 0);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 flags", {dma_req, rx_nak, irq_pkt, irq_short, irq_zlp}, 0);

        // R2 R6 R7 short good packet
        send_out(5, 8'h10, 1, 1);
        chk("R6 irq_short", {irq_pkt, irq_short, irq_zlp}, 3'b010);
        chk("R2 out_avail", out_avail, 1);
        chk("R2 out_len", out_len, 5);
        chk("R7 no dma on short", dma_req, 0);
        @(negedge clk);
        chk("R6 irq one cycle", irq_short, 0);
        drain(5);
        chk("R5 freed", out_avail, 0);

        // R3 bad CRC
        send_out(4, 8'h20, 0, 1);
        chk("R3 nak", rx_nak, 1);
        chk("R3 no irq", {irq_pkt, irq_short, irq_zlp}, 0);
        chk("R3 discarded", out_avail, 0);
        @(negedge clk);
        chk("R3 nak one cycle", rx_nak, 0);

        // R7 full-size packet and DMA chunk boundary
        send_out(MAXP, 8'h40, 1, 1);
        chk("R6 irq_pkt", {irq_pkt, irq_short, irq_zlp}, 3'b100);
        chk("R7 dma at start", dma_req, 1);
        drain(32);
        chk("R7 dma with 32 left", dma_req, 1);
        drain(1);
        chk("R7 dma below chunk", dma_req, 0);
        drain(MAXP - 33);
        chk("R5 full-size freed", out_avail, 0);

        // R6 zero-length packet
        send_out(0, 8'h00, 1, 1);
        chk("R6 irq_zlp", {irq_pkt, irq_short, irq_zlp}, 3'b001);
        chk("R6 zlp len", out_len, 0);
        chk("R6 zlp last", out_last, 1);
        drain(1);
        chk("R5 zlp freed", out_avail, 0);

        // R4 both buffers held, third packet ignored
        send_out(3, 8'h60, 1, 1);
        send_out(7, 8'h70, 1, 1);
        chk("R4 busy", rx_busy, 1);
        send_out(5, 8'h80, 1, 0);
        chk("R4 ignored no irq", {irq_pkt, irq_short, irq_zlp}, 0);
        chk("R4 ignored no nak", rx_nak, 0);
        chk("R4 first len", out_len, 3);
        drain(3);
        chk("R5 second presented", out_len, 7);
        chk("R4 busy released", rx_busy, 0);
        drain(7);
        chk("R4 nothing extra", out_avail, 0);
        chk("R4 queue empty", exp_q.size(), 0);

        // R3 over-length packet
        send_out(MAXP + 1, 8'h00, 1, 1);
        chk("R3 overlength nak", rx_nak, 1);
        chk("R3 overlength dropped", out_avail, 0);

        // R8 R9 IN packet and retry
        in_write(4, 8'hA0);
        chk("R8 not yet avail", in_avail, 0);
        pulse_commit();
        chk("R8 in_avail", in_avail, 1);
        chk("R8 in_len", in_len, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R8 in_data", in_data, 8'hA0 + i);
            chk("R8 in_last", in_last, (i == 3));
            in_step();
        end
        pulse_retry();
        chk("R9 rewind", in_data, 8'hA0);
        in_step(); in_step();
        chk("R9 after rewind", in_data, 8'hA2);
        pulse_retry();
        chk("R9 second rewind", in_data, 8'hA0);
        chk("R9 len kept", in_len, 4);

        // R11 R10 both IN buffers held
        in_write(2, 8'hB0);
        pulse_commit();
        chk("R11 tx_ready low", tx_ready, 0);
        in_write(1, 8'hC0);
        pulse_commit();
        pulse_ack();
        chk("R10 tx_ready", tx_ready, 1);
        chk("R10 next len", in_len, 2);
        chk("R10 next data", in_data, 8'hB0);
        pulse_ack();
        chk("R11 blocked packet not stored", in_avail, 0);

        // R12 length saturation
        in_write(MAXP + 6, 8'h00);
        pulse_commit();
        chk("R12 saturated len", in_len, MAXP);
        chk("R12 first byte", in_data, 8'h00);
        pulse_ack();
        chk("R10 emptied", in_avail, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule